// File: doc/BRIEF.md
# Two-Stage Lockable Watchdog Timer

This block supervises host software with a countdown that escalates in two steps. Software loads a timeout in 8 µs ticks, turns the timer on, and then services it at intervals by writing the reload register. If the timeout passes without service, a warning interrupt goes high and stays high. If a second timeout then passes with no service, the block issues a one-cycle reset request and records it in a sticky status bit. The timer then starts over in its first stage.

A free-running prescaler on the system clock produces the ticks. The timeout is a 24-bit tick count, so the interval runs from a single 8 µs tick to more than two minutes. A lock bit freezes the enable bit and the timeout value until the next reset. Software can therefore make sure that no later write switches the watchdog off. All access goes through a byte-wide write port with a 4-bit offset. Reads are combinational from the same offset.

Top module: `wdog_two_stage`

## Requirements
- R1: After reset the timer is disabled and unlocked. `warn_irq` and `rst_req` are low, the status reads 0x00, and the timeout bytes read back the `TMO_RST` parameter value.
- R2: The control register sits at offset 0x8, with bit 0 as run enable and bit 1 as lock. Bits 7:2 read as 0. The timeout is a 24-bit tick count held at offsets 0x0 (bits 7:0), 0x1 (bits 15:8) and 0x2 (bits 23:16), and all three bytes read back what was written.
- R3: Once lock is 1, writes to offset 0x8 and to offsets 0x0–0x2 are ignored. Only reset clears the lock. Reload still works while the timer is locked.
- R4: A tick occurs every `CLK_PER_TICK` clocks. With a timeout of N, `warn_irq` rises exactly N·`CLK_PER_TICK` cycles after the edge that enables the timer or reloads it. A timeout of 0 behaves as 1.
- R5: A write of any data to offset 0xA while the timer is enabled restarts the first stage and the prescaler, and clears `warn_irq` at that edge.
- R6: If no service follows for N more ticks after the warning, `rst_req` is high for exactly one cycle and status bit 1 is set. The warning clears at the same edge and the first stage starts again.
- R7: The status register at offset 0xC shows the warning in bit 0 and the latched reset request in bit 1. Writing 1 to bit 1 clears the latch.
- R8: While the timer is disabled, a reload write has no effect and no warning or reset request appears. Disabling the timer clears the warning and both stages at the same edge.
- R9: Once raised, `warn_irq` stays high until a reload, a disable, or the second-stage expiry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 4 | Register offset |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` |
| warn_irq | output | 1 | First-stage warning, level |
| rst_req | output | 1 | Second-stage reset request, one-cycle pulse |

## Verification
On every cycle the assertions check the following:
- the reset request lasts one cycle, follows a warning, and is recorded in the status latch;
- the lock never drops and the enable never changes under lock;
- a disabled timer shows no warning;
- a reload while enabled clears the warning.

Only the bench scenarios can show the exact expiry cycles of both stages for various timeouts. The same goes for the case where a timeout of zero behaves as one, for locked writes leaving the read-back values unchanged, and for a reload while disabled leaving the timer idle.

// File: rtl/wdog_two_stage.sv
module wdog_two_stage #(
  parameter int          CLK_PER_TICK = 400,
  parameter logic [23:0] TMO_RST      = 24'd125000
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [3:0] addr,
  input  logic [7:0] wdata,
  output logic [7:0] rd_data,
  output logic       warn_irq,
  output logic       rst_req
);
  localparam int PRE_W = (CLK_PER_TICK > 1) ? $clog2(CLK_PER_TICK) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_PER_TICK - 1);

  logic             en, lock, rst_flag;
  logic [PRE_W-1:0] pre;
  logic [23:0]      cnt, tmo;

  wire        wr_ctrl = wr_en && addr == 4'h8;
  wire        wr_rld  = wr_en && addr == 4'hA && en;
  wire        en_next = (wr_ctrl && !lock) ? wdata[0] : en;
  wire        tick    = pre == PRE_LAST;
  wire [23:0] tmo_eff = (tmo == 24'd0) ? 24'd1 : tmo;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en       <= 1'b0;
      lock     <= 1'b0;
      tmo      <= TMO_RST;
      pre      <= '0;
      cnt      <= 24'd1;
      warn_irq <= 1'b0;
      rst_req  <= 1'b0;
      rst_flag <= 1'b0;
    end else begin
      rst_req <= 1'b0;
      if (wr_ctrl && !lock) begin
        en   <= wdata[0];
        lock <= wdata[1];
      end
      for (int i = 0; i < 3; i++)
        if (wr_en && !lock && addr == 4'(i)) tmo[i*8 +: 8] <= wdata;
      if (wr_en && addr == 4'hC && wdata[1]) rst_flag <= 1'b0;

      if (!en_next || !en || wr_rld) begin
        pre      <= '0;
        cnt      <= tmo_eff;
        warn_irq <= 1'b0;
      end else begin
        pre <= tick ? '0 : pre + 1'b1;
        if (tick) begin
          if (cnt <= 24'd1) begin
            cnt <= tmo_eff;
            if (!warn_irq) warn_irq <= 1'b1;
            else begin
              warn_irq <= 1'b0;
              rst_req  <= 1'b1;
              rst_flag <= 1'b1;
            end
          end else begin
            cnt <= cnt - 24'd1;
          end
        end
      end
    end
  end

  always_comb begin
    case (addr)
      4'h0:    rd_data = tmo[7:0];
      4'h1:    rd_data = tmo[15:8];
      4'h2:    rd_data = tmo[23:16];
      4'h8:    rd_data = {6'b0, lock, en};
      4'hC:    rd_data = {6'b0, rst_flag, warn_irq};
      default: rd_data = 8'h00;
    endcase
  end

  assert_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req);
  assert_flag_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> rst_flag);
  assert_warn_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> $past(warn_irq));
  assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> lock);
  assert_lock_en_R3: assert property (@(posedge clk) disable iff (!rst_n)
    lock |=> $stable(en));
  assert_off_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !en |-> (!warn_irq && !rst_req));
  assert_reload_clr_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_en && addr == 4'hA) |=> !warn_irq);
endmodule

// File: tb/tb_wdog_two_stage.sv
`timescale 1ns/1ps
module tb_wdog_two_stage;
  localparam int P = 3;
  localparam logic [23:0] TRST = 24'd5;

  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
  logic [3:0] addr = 4'h0;
  logic [7:0] wdata = 8'h00;
  logic [7:0] rd_data;
  logic warn_irq, rst_req;
  int total = 0, bad = 0;
  bit done = 0;

  wdog_two_stage #(.CLK_PER_TICK(P), .TMO_RST(TRST)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rd_data(rd_data), .warn_irq(warn_irq), .rst_req(rst_req));

  always #10 clk = ~clk;

  function automatic logic exp_warn(int n, int d);
    return d >= n * P;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(logic [3:0] a, output logic [7:0] v);
    addr = a; #1; v = rd_data;
  endtask

  task automatic step(int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic set_tmo(int n);
    wr(4'h0, 8'(n)); wr(4'h1, 8'h00); wr(4'h2, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired act=running exp=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    int n, d;
    void'($urandom(32'd4711));
    step(3); rst_n = 1'b1; step(1);

    chk("R1 warn", warn_irq, 0); chk("R1 rst_req", rst_req, 0);
    rd(4'h8, v); chk("R1 ctrl", v, 8'h00);
    rd(4'hC, v); chk("R1 status", v, 8'h00);
    rd(4'h0, v); chk("R1 tmo0", v, TRST[7:0]);
    rd(4'h1, v); chk("R1 tmo1", v, 8'h00);

    wr(4'h0, 8'h56); wr(4'h1, 8'h34); wr(4'h2, 8'h12);
    rd(4'h0, v); chk("R2 tmo0", v, 8'h56);
    rd(4'h1, v); chk("R2 tmo1", v, 8'h34);
    rd(4'h2, v); chk("R2 tmo2", v, 8'h12);
    wr(4'h8, 8'hFC);
    rd(4'h8, v); chk("R2 reserved zero", v, 8'h00);

    n = 4; set_tmo(n);
    wr(4'h8, 8'h01);
    rd(4'h8, v); chk("R2 enable bit", v, 8'h01);
    step(n*P - 1); chk("R4 before expiry", warn_irq, 0);
    step(1);       chk("R4 at expiry", warn_irq, 1);
    step(2);       chk("R9 held", warn_irq, 1);
    wr(4'hA, 8'h00); chk("R5 reload clears", warn_irq, 0);
    step(n*P - 1); chk("R5 restart before", warn_irq, 0);
    step(1);       chk("R5 restart expiry", warn_irq, 1);
    step(n*P - 1); chk("R6 no pulse yet", rst_req, 0);
    chk("R9 held to end", warn_irq, 1);
    step(1);       chk("R6 pulse", rst_req, 1);
    chk("R6 warn cleared", warn_irq, 0);
    rd(4'hC, v);   chk("R7 status latch", v, 8'h02);
    step(1);       chk("R6 one cycle", rst_req, 0);
    wr(4'hC, 8'h02);
    rd(4'hC, v);   chk("R7 latch cleared", v[1], 0);

    step(n*P - 2);
    rd(4'hC, v); chk("R7 warn bit", v, 8'h01);
    wr(4'h8, 8'h00); chk("R8 disable clears", warn_irq, 0);
    wr(4'hA, 8'h00);
    rd(4'h8, v); chk("R8 reload while off", v, 8'h00);
    step(3*n*P);
    chk("R8 stays idle", warn_irq, 0);
    rd(4'hC, v); chk("R8 no latch", v, 8'h00);

    set_tmo(0); wr(4'h8, 8'h01);
    step(P - 1); chk("R4 zero before", warn_irq, 0);
    step(1);     chk("R4 zero as one", warn_irq, 1);

    for (int i = 0; i < 25; i++) begin
      n = 1 + int'($urandom % 6);
      d = 1 + int'($urandom % (2*n*P - 1));
      wr(4'h8, 8'h00); set_tmo(n); wr(4'h8, 8'h01);
      step(d); chk("R4 random", warn_irq, exp_warn(n, d));
      wr(4'hA, 8'h00); chk("R5 random reload", warn_irq, 0);
    end

    wr(4'h8, 8'h00); set_tmo(4); wr(4'h8, 8'h03);
    rd(4'h8, v); chk("R3 locked", v, 8'h03);
    wr(4'h8, 8'h00);
    rd(4'h8, v); chk("R3 ctrl frozen", v, 8'h03);
    wr(4'h0, 8'h09);
    rd(4'h0, v); chk("R3 tmo frozen", v, 8'h04);
    step(4*P);   chk("R3 still runs", warn_irq, 1);
    wr(4'hA, 8'h00); chk("R3 reload under lock", warn_irq, 0);
    @(negedge clk); rst_n = 1'b0; step(2); rst_n = 1'b1; step(1);
    rd(4'h8, v); chk("R3 reset unlocks", v, 8'h00);
    rd(4'h0, v); chk("R1 tmo after reset", v, TRST[7:0]);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule